// File: doc/BRIEF.md
# Prioritized Interrupt Entry and Return Sequencer

This block is the interrupt controller for a small 8-bit processor core. It masks a vector of pending request flags with a per-source enable mask and a global enable bit, and picks the lowest-numbered survivor. At an instruction boundary, or at once when the core is asleep, it takes that source. It saves the 16-bit program counter on a byte-wide stack port, lowers the stack pointer, drives the vector address to the program counter and pulses an acknowledge to the winning source.

On a return request it pops the two saved bytes in reverse order and raises the stack pointer again. It then reloads the program counter and sets the global enable bit. Every sequence has a fixed cycle count. A base-select input moves the vector table from address 0 to a boot section. A separate static input moves only the reset vector. The core is held (`busy`) for the whole of any sequence.

Top module: `intSequencer`

## Requirements
- R1: No source is taken unless its enable bit and the global enable bit are both 1: with either bit low for every pending source, `busy` stays 0 and no acknowledge is given.
- R2: Pending bit i is vector index i+1 (index 0 is reset). Among taken-able sources the lowest index wins, and the loaded vector address is base + 2 × index.
- R3: Taking an interrupt clears the global enable bit, so no further source is taken until it is set again.
- R4: Software writes of the global enable (`gieWrEn`/`gieWrVal`) apply only while idle. Setting it inside a routine lets any enabled pending source nest. Each nested entry pushes two more bytes.
- R5: Entry lasts exactly 4 cycles after the accepting edge. Cycle 1 writes the PC low byte at SP, cycle 2 writes the high byte at SP−1, and SP ends 2 lower. `pcLoad` is high in cycle 4.
- R6: A source is taken only on a cycle with `instrBoundary` high (or with the core asleep). Without that, it waits.
- R7: If the core is asleep when a source is taken, 4 extra cycles with `wakeUp` high come first, so `pcLoad` falls in cycle 8.
- R8: A return lasts 4 cycles. It reads the high byte at SP+1 and the low byte at SP+2, and SP ends 2 higher. `pcLoad` in cycle 4 carries the saved PC, and the global enable reads 1 after that cycle.
- R9: With `vecSel` = 1 the vector base is BOOT_BASE, otherwise 0. `resetVector` is BOOT_BASE when `rstBootSel` = 1, otherwise 0.
- R10: The acknowledge is one-hot (bit i for index i+1), lasts one cycle, and coincides with the vector `pcLoad`. A return gives no acknowledge.
- R11: When a return request and a valid interrupt fall in the same idle cycle, the return is performed first. The interrupt is taken at a later boundary.
- R12: After reset the global enable is 0, SP is SP_INIT, and `busy`, `pcLoad`, `stackWrEn` and `irqAck` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqPending | input | NUM_SRC | Pending flags; bit i is vector index i+1 |
| irqEnable | input | NUM_SRC | Per-source enable mask |
| instrBoundary | input | 1 | Core is between instructions |
| cpuAsleep | input | 1 | Core is in sleep |
| retiReq | input | 1 | Return-from-interrupt request |
| pcIn | input | 16 | PC to save on entry |
| gieWrEn | input | 1 | Software write strobe for global enable |
| gieWrVal | input | 1 | Value written to global enable |
| vecSel | input | 1 | Vector table base select (1 = boot section) |
| rstBootSel | input | 1 | Static reset vector placement select |
| stackRdData | input | 8 | Stack read data, one cycle after `stackRdEn` |
| globalEn | output | 1 | Global interrupt enable bit |
| busy | output | 1 | Sequence in progress, core held |
| wakeUp | output | 1 | High during the sleep wake-up penalty |
| stackWrEn | output | 1 | Stack byte write strobe |
| stackRdEn | output | 1 | Stack byte read strobe |
| stackAddr | output | SP_W | Stack byte address |
| stackWrData | output | 8 | Stack write data |
| spOut | output | SP_W | Current stack pointer |
| pcLoad | output | 1 | Load `pcLoadValue` into the PC |
| pcLoadValue | output | 16 | Vector or restored PC |
| irqAck | output | NUM_SRC | One-cycle acknowledge of the taken source |
| resetVector | output | 16 | Reset start address |

## Verification
A return request and an interrupt acceptance can fall in the same idle cycle once software has set the global enable inside a routine. The bench raises `retiReq` and `instrBoundary` on the same cycle while an enabled source is pending. It judges the result by the first `pcLoad`: it must carry the popped PC with no acknowledge. It then checks that the still-pending source is taken at the next boundary with the correct vector.

// File: rtl/intSeqPkg.sv
package intSeqPkg;

  localparam int PC_W = 16;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAKE,
    S_PUSH_LO,
    S_PUSH_HI,
    S_ENT_GAP,
    S_ENT_VEC,
    S_POP_HI,
    S_POP_LO,
    S_RET_CAP,
    S_RET_LOAD
  } seqState_t;

  typedef struct packed {
    logic accept;   // capture PC, winner and base; clear global enable
    logic pushLo;   // write PC low byte at SP, SP--
    logic pushHi;   // write PC high byte at SP, SP--
    logic loadVec;  // drive vector, acknowledge
    logic popHi;    // read SP+1, SP++
    logic popLo;    // read SP+1, SP++, capture high byte
    logic capLo;    // capture low byte
    logic loadRet;  // drive restored PC, set global enable
    logic swWrOk;   // software may write global enable
  } seqStrobe_t;

endpackage

// File: rtl/intSeqArbiter.sv
module intSeqArbiter #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] irqPending,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic               gie,
  output logic               winValid,
  output logic [IDX_W-1:0]   winIdx
);

  logic [NUM_SRC-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gMask
      assign eligible[g] = irqPending[g] & irqEnable[g] & gie;
    end
  endgenerate

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) winIdx = IDX_W'(i + 1);
    end
  end

  assign winValid = |eligible;

endmodule

// File: rtl/intSeqCtrl.sv
module intSeqCtrl
  import intSeqPkg::*;
#(
  parameter int WAKE_CYC = 4,
  localparam int CNT_W = $clog2(WAKE_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       winValid,
  input  logic       instrBoundary,
  input  logic       cpuAsleep,
  input  logic       retiReq,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       wakeUp
);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] wakeCnt;
  logic takeRet, takeIrq;

  assign takeRet = (state == S_IDLE) && retiReq;
  assign takeIrq = (state == S_IDLE) && !retiReq && winValid &&
                   (instrBoundary || cpuAsleep);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (takeRet)      stateNext = S_POP_HI;
        else if (takeIrq) stateNext = cpuAsleep ? S_WAKE : S_PUSH_LO;
      end
      S_WAKE:     if (wakeCnt == CNT_W'(WAKE_CYC - 1)) stateNext = S_PUSH_LO;
      S_PUSH_LO:  stateNext = S_PUSH_HI;
      S_PUSH_HI:  stateNext = S_ENT_GAP;
      S_ENT_GAP:  stateNext = S_ENT_VEC;
      S_ENT_VEC:  stateNext = S_IDLE;
      S_POP_HI:   stateNext = S_POP_LO;
      S_POP_LO:   stateNext = S_RET_CAP;
      S_RET_CAP:  stateNext = S_RET_LOAD;
      S_RET_LOAD: stateNext = S_IDLE;
      default:    stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wakeCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_WAKE) wakeCnt <= wakeCnt + 1'b1;
      else                 wakeCnt <= '0;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.accept  = takeIrq;
    strobe.pushLo  = (state == S_PUSH_LO);
    strobe.pushHi  = (state == S_PUSH_HI);
    strobe.loadVec = (state == S_ENT_VEC);
    strobe.popHi   = (state == S_POP_HI);
    strobe.popLo   = (state == S_POP_LO);
    strobe.capLo   = (state == S_RET_CAP);
    strobe.loadRet = (state == S_RET_LOAD);
    strobe.swWrOk  = (state == S_IDLE);
  end

  assign busy   = (state != S_IDLE);
  assign wakeUp = (state == S_WAKE);

endmodule

// File: rtl/intSeqDatapath.sv
module intSeqDatapath
  import intSeqPkg::*;
#(
  parameter int              NUM_SRC   = 8,
  parameter int              SP_W      = 16,
  parameter logic [SP_W-1:0] SP_INIT   = 16'h00FF,
  parameter logic [PC_W-1:0] BOOT_BASE = 16'h3800,
  localparam int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [IDX_W-1:0]   winIdx,
  input  logic [PC_W-1:0]    pcIn,
  input  logic               vecSel,
  input  logic               gieWrEn,
  input  logic               gieWrVal,
  input  logic [7:0]         stackRdData,
  output logic               gie,
  output logic               stackWrEn,
  output logic               stackRdEn,
  output logic [SP_W-1:0]    stackAddr,
  output logic [7:0]         stackWrData,
  output logic [SP_W-1:0]    sp,
  output logic               pcLoad,
  output logic [PC_W-1:0]    pcLoadValue,
  output logic [NUM_SRC-1:0] irqAck
);

  logic [PC_W-1:0]  savedPc;
  logic [IDX_W-1:0] ackIdx;
  logic             baseBoot;
  logic [7:0]       retHi, retLo;
  logic [PC_W-1:0]  vecAddr;
  logic             popping;

  assign popping = strobe.popHi | strobe.popLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp       <= SP_INIT;
      savedPc  <= '0;
      ackIdx   <= '0;
      baseBoot <= 1'b0;
      retHi    <= '0;
      retLo    <= '0;
      gie      <= 1'b0;
    end else begin
      if (strobe.pushLo || strobe.pushHi) sp <= sp - 1'b1;
      else if (popping)                   sp <= sp + 1'b1;

      if (strobe.accept) begin
        savedPc  <= pcIn;
        ackIdx   <= winIdx;
        baseBoot <= vecSel;
      end

      if (strobe.popLo) retHi <= stackRdData;
      if (strobe.capLo) retLo <= stackRdData;

      if (strobe.accept)                 gie <= 1'b0;
      else if (strobe.loadRet)           gie <= 1'b1;
      else if (strobe.swWrOk && gieWrEn) gie <= gieWrVal;
    end
  end

  assign vecAddr = (baseBoot ? BOOT_BASE : '0) + PC_W'({ackIdx, 1'b0});

  assign stackWrEn   = strobe.pushLo | strobe.pushHi;
  assign stackWrData = strobe.pushHi ? savedPc[15:8] : savedPc[7:0];
  assign stackRdEn   = popping;
  assign stackAddr   = popping ? (sp + 1'b1) : sp;

  assign pcLoad      = strobe.loadVec | strobe.loadRet;
  assign pcLoadValue = strobe.loadVec ? vecAddr : {retHi, retLo};

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gAck
      assign irqAck[g] = strobe.loadVec && (ackIdx == IDX_W'(g + 1));
    end
  endgenerate

endmodule

// File: rtl/intSequencer.sv
module intSequencer
  import intSeqPkg::*;
#(
  parameter int              NUM_SRC   = 8,
  parameter int              SP_W      = 16,
  parameter logic [SP_W-1:0] SP_INIT   = 16'h00FF,
  parameter logic [15:0]     BOOT_BASE = 16'h3800,
  parameter int              WAKE_CYC  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqPending,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic               instrBoundary,
  input  logic               cpuAsleep,
  input  logic               retiReq,
  input  logic [15:0]        pcIn,
  input  logic               gieWrEn,
  input  logic               gieWrVal,
  input  logic               vecSel,
  input  logic               rstBootSel,
  input  logic [7:0]         stackRdData,
  output logic               globalEn,
  output logic               busy,
  output logic               wakeUp,
  output logic               stackWrEn,
  output logic               stackRdEn,
  output logic [SP_W-1:0]    stackAddr,
  output logic [7:0]         stackWrData,
  output logic [SP_W-1:0]    spOut,
  output logic               pcLoad,
  output logic [15:0]        pcLoadValue,
  output logic [NUM_SRC-1:0] irqAck,
  output logic [15:0]        resetVector
);

  localparam int IDX_W = $clog2(NUM_SRC + 1);

  seqStrobe_t       strobe;
  logic             winValid;
  logic [IDX_W-1:0] winIdx;

  intSeqArbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .irqPending(irqPending),
    .irqEnable (irqEnable),
    .gie       (globalEn),
    .winValid  (winValid),
    .winIdx    (winIdx)
  );

  intSeqCtrl #(.WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .winValid     (winValid),
    .instrBoundary(instrBoundary),
    .cpuAsleep    (cpuAsleep),
    .retiReq      (retiReq),
    .strobe       (strobe),
    .busy         (busy),
    .wakeUp       (wakeUp)
  );

  intSeqDatapath #(
    .NUM_SRC  (NUM_SRC),
    .SP_W     (SP_W),
    .SP_INIT  (SP_INIT),
    .BOOT_BASE(BOOT_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .winIdx     (winIdx),
    .pcIn       (pcIn),
    .vecSel     (vecSel),
    .gieWrEn    (gieWrEn),
    .gieWrVal   (gieWrVal),
    .stackRdData(stackRdData),
    .gie        (globalEn),
    .stackWrEn  (stackWrEn),
    .stackRdEn  (stackRdEn),
    .stackAddr  (stackAddr),
    .stackWrData(stackWrData),
    .sp         (spOut),
    .pcLoad     (pcLoad),
    .pcLoadValue(pcLoadValue),
    .irqAck     (irqAck)
  );

  assign resetVector = rstBootSel ? BOOT_BASE : 16'h0000;

endmodule

// File: rtl/intSequencer_chk.sv
module intSequencer_chk #(
  parameter int NUM_SRC = 8,
  parameter int SP_W    = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               retiReq,
  input logic               globalEn,
  input logic               busy,
  input logic               wakeUp,
  input logic               stackWrEn,
  input logic               stackRdEn,
  input logic [SP_W-1:0]    spOut,
  input logic               pcLoad,
  input logic [NUM_SRC-1:0] irqAck
);

  // R1: with the global enable low and no return request, nothing starts
  assert_no_start_masked_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !globalEn && !retiReq) |=> !busy);

  // R3: the vector load happens with the global enable already cleared
  assert_gie_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && (irqAck != '0)) |-> !globalEn);

  // R5: every stack write lowers the stack pointer by one
  assert_push_sp_R5: assert property (@(posedge clk) disable iff (!rstN)
    stackWrEn |=> (spOut == $past(spOut) - 1'b1));

  // R5: stack port never reads and writes together
  assert_port_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(stackWrEn && stackRdEn));

  // R7: the wake-up penalty lies inside a busy sequence, before any load
  assert_wake_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> (busy && !pcLoad && !stackWrEn));

  // R8: a load without acknowledge is a return and sets the global enable
  assert_ret_gie_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && (irqAck == '0)) |=> globalEn);

  // R10: acknowledge is one-hot, tied to the load, and one cycle long
  assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqAck));
  assert_ack_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck != '0) |-> pcLoad);
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck != '0) |=> (irqAck == '0));

endmodule

bind intSequencer intSequencer_chk #(.NUM_SRC(NUM_SRC), .SP_W(SP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .retiReq  (retiReq),
  .globalEn (globalEn),
  .busy     (busy),
  .wakeUp   (wakeUp),
  .stackWrEn(stackWrEn),
  .stackRdEn(stackRdEn),
  .spOut    (spOut),
  .pcLoad   (pcLoad),
  .irqAck   (irqAck)
);

// File: tb/intSequencer_tb.sv
module intSequencer_tb;

  localparam int          NS   = 8;
  localparam logic [15:0] SP0  = 16'h00FF;
  localparam logic [15:0] BOOT = 16'h3800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] irqPending = '0, irqEnable = '0;
  logic instrBoundary = 0, cpuAsleep = 0, retiReq = 0;
  logic [15:0] pcIn = '0;
  logic gieWrEn = 0, gieWrVal = 0, vecSel = 0, rstBootSel = 0;
  logic [7:0] stackRdData;
  logic globalEn, busy, wakeUp, stackWrEn, stackRdEn, pcLoad;
  logic [15:0] stackAddr, spOut, pcLoadValue, resetVector;
  logic [7:0] stackWrData;
  logic [NS-1:0] irqAck;

  int nChecks = 0, nFail = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  intSequencer u_dut (
    .clk(clk), .rstN(rstN), .irqPending(irqPending), .irqEnable(irqEnable),
    .instrBoundary(instrBoundary), .cpuAsleep(cpuAsleep), .retiReq(retiReq),
    .pcIn(pcIn), .gieWrEn(gieWrEn), .gieWrVal(gieWrVal), .vecSel(vecSel),
    .rstBootSel(rstBootSel), .stackRdData(stackRdData), .globalEn(globalEn),
    .busy(busy), .wakeUp(wakeUp), .stackWrEn(stackWrEn), .stackRdEn(stackRdEn),
    .stackAddr(stackAddr), .stackWrData(stackWrData), .spOut(spOut),
    .pcLoad(pcLoad), .pcLoadValue(pcLoadValue), .irqAck(irqAck),
    .resetVector(resetVector)
  );

  // byte stack memory, one-cycle read latency
  always @(posedge clk) begin
    if (stackWrEn) mem[stackAddr[7:0]] <= stackWrData;
    if (stackRdEn) stackRdData <= mem[stackAddr[7:0]];
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setGie(input logic v);
    @(negedge clk); gieWrEn = 1; gieWrVal = v;
    @(negedge clk); gieWrEn = 0;
  endtask

  // accept at the next edge, then count cycles until pcLoad
  task automatic doEntry(input logic [15:0] pc, input logic asleep,
                         output int cyc, output int wakeCyc);
    @(negedge clk);
    pcIn = pc;
    if (asleep) cpuAsleep = 1; else instrBoundary = 1;
    @(negedge clk);
    instrBoundary = 0;
    cyc = 1; wakeCyc = 0;
    while (!pcLoad && cyc < 40) begin
      if (wakeUp) wakeCyc++;
      @(negedge clk); cyc++;
    end
    cpuAsleep = 0;
  endtask

  task automatic doReturn(output int cyc);
    @(negedge clk); retiReq = 1;
    @(negedge clk); retiReq = 0;
    cyc = 1;
    while (!pcLoad && cyc < 40) begin
      @(negedge clk); cyc++;
    end
  endtask

  // {pending, enable, vecSel, expected vector, expected ack}
  localparam int NV = 6;
  localparam logic [40:0] TBL [NV] = '{
    {8'h01, 8'hFF, 1'b0, 16'h0002, 8'h01},
    {8'h06, 8'hFF, 1'b0, 16'h0004, 8'h02},
    {8'h06, 8'hFD, 1'b0, 16'h0006, 8'h04},
    {8'h80, 8'h80, 1'b1, 16'h3810, 8'h80},
    {8'hF0, 8'h30, 1'b1, 16'h380A, 8'h10},
    {8'hFF, 8'hFF, 1'b0, 16'h0002, 8'h01}
  };

  initial begin
    #(20 * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int cyc, wk;
    logic [15:0] pc;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(globalEn == 0 && busy == 0 && pcLoad == 0 && stackWrEn == 0 && irqAck == 0,
          "R12 reset outputs", {busy, pcLoad, globalEn}, 0);
    check(spOut == SP0, "R12 reset SP", spOut, SP0);
    rstN = 1;
    @(negedge clk);
    // R9 reset vector placement
    check(resetVector == 16'h0000, "R9 reset vector low", resetVector, 0);
    rstBootSel = 1; #1;
    check(resetVector == BOOT, "R9 reset vector boot", resetVector, BOOT);
    rstBootSel = 0;

    // table of entries, each followed by a return
    for (int v = 0; v < NV; v++) begin
      pc = 16'h1200 + 16'(v) * 16'h0111;
      setGie(1);
      irqPending = TBL[v][40:33]; irqEnable = TBL[v][32:25]; vecSel = TBL[v][24];
      doEntry(pc, 0, cyc, wk);
      check(cyc == 4, "R5 entry cycles", cyc, 4);
      check(pcLoadValue == TBL[v][23:8], "R2 R9 vector address", pcLoadValue, TBL[v][23:8]);
      check(irqAck == TBL[v][7:0], "R10 acknowledge", irqAck, TBL[v][7:0]);
      check(globalEn == 0, "R3 enable cleared", globalEn, 0);
      check(spOut == SP0 - 2, "R5 SP after entry", spOut, SP0 - 2);
      check(mem[SP0[7:0]] == pc[7:0] && mem[8'(SP0 - 1)] == pc[15:8], "R5 pushed bytes",
            {mem[8'(SP0 - 1)], mem[SP0[7:0]]}, pc);
      irqPending = '0;
      @(negedge clk);
      check(irqAck == 0, "R10 ack single cycle", irqAck, 0);
      doReturn(cyc);
      check(cyc == 4, "R8 return cycles", cyc, 4);
      check(pcLoadValue == pc && irqAck == 0, "R8 restored PC", pcLoadValue, pc);
      @(negedge clk);
      check(globalEn == 1, "R8 enable set", globalEn, 1);
      check(spOut == SP0, "R8 SP restored", spOut, SP0);
      setGie(0);
    end
    vecSel = 0;

    // R1: enable mask blocks
    setGie(1);
    irqPending = 8'h0F; irqEnable = 8'hF0;
    @(negedge clk); instrBoundary = 1;
    repeat (4) @(negedge clk);
    check(busy == 0, "R1 masked by source enable", busy, 0);
    // R1: global enable low blocks
    setGie(0);
    irqEnable = 8'hFF;
    repeat (4) @(negedge clk);
    check(busy == 0, "R1 masked by global enable", busy, 0);
    instrBoundary = 0;

    // R6: no boundary, no entry; then boundary accepts
    setGie(1);
    repeat (5) @(negedge clk);
    check(busy == 0, "R6 waits for boundary", busy, 0);
    doEntry(16'h4321, 0, cyc, wk);
    check(cyc == 4 && pcLoadValue == 16'h0002, "R6 entry at boundary", pcLoadValue, 2);
    // R3: further request blocked while enable is clear
    irqPending = 8'h02; irqEnable = 8'h02;
    @(negedge clk); instrBoundary = 1;
    repeat (4) @(negedge clk);
    check(busy == 0, "R3 blocked after entry", busy, 0);
    instrBoundary = 0;
    irqPending = 0;
    doReturn(cyc);
    check(pcLoadValue == 16'h4321, "R8 return after blocked", pcLoadValue, 16'h4321);
    @(negedge clk);

    // R7: entry from sleep
    irqPending = 8'h04; irqEnable = 8'h04;
    doEntry(16'h0ABC, 1, cyc, wk);
    check(cyc == 8, "R7 sleep entry cycles", cyc, 8);
    check(wk == 4, "R7 wake cycles", wk, 4);
    check(pcLoadValue == 16'h0006, "R7 sleep vector", pcLoadValue, 6);
    irqPending = 0;
    doReturn(cyc);
    check(pcLoadValue == 16'h0ABC, "R7 return PC", pcLoadValue, 16'h0ABC);
    @(negedge clk);

    // R4: nesting
    irqPending = 8'h08; irqEnable = 8'hFF;
    doEntry(16'h2222, 0, cyc, wk);
    irqPending = 0;
    check(pcLoadValue == 16'h0008, "R4 outer vector", pcLoadValue, 8);
    setGie(1);
    irqPending = 8'h20;
    doEntry(16'h3333, 0, cyc, wk);
    irqPending = 0;
    check(pcLoadValue == 16'h000C, "R4 nested vector", pcLoadValue, 12);
    check(spOut == SP0 - 4, "R4 nested SP", spOut, SP0 - 4);
    doReturn(cyc);
    check(pcLoadValue == 16'h3333, "R4 inner return", pcLoadValue, 16'h3333);
    doReturn(cyc);
    check(pcLoadValue == 16'h2222, "R4 outer return", pcLoadValue, 16'h2222);
    @(negedge clk);
    check(spOut == SP0, "R4 SP unwound", spOut, SP0);

    // R11: return and acceptance in the same idle cycle
    irqPending = 8'h01;
    doEntry(16'h5555, 0, cyc, wk);
    irqPending = 0;
    setGie(1);
    irqPending = 8'h40;
    @(negedge clk); retiReq = 1; instrBoundary = 1; pcIn = 16'h7777;
    @(negedge clk); retiReq = 0; instrBoundary = 0;
    cyc = 1;
    while (!pcLoad && cyc < 40) begin @(negedge clk); cyc++; end
    check(cyc == 4 && pcLoadValue == 16'h5555 && irqAck == 0, "R11 return first",
          pcLoadValue, 16'h5555);
    @(negedge clk);
    check(globalEn == 1, "R11 enable after return", globalEn, 1);
    doEntry(16'h6666, 0, cyc, wk);
    check(pcLoadValue == 16'h000E && irqAck == 8'h40, "R11 later entry", pcLoadValue, 14);
    irqPending = 0;
    doReturn(cyc);
    check(pcLoadValue == 16'h6666, "R11 final return", pcLoadValue, 16'h6666);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule